// File: doc/BRIEF.md
# Multiplexed LED Fuel Gauge Display

This block turns a battery's available-charge count into a five-segment LED bar and a 4-bit gauge field in sixteenths. The charge is first derated for cold, using a coarse temperature band and a hysteresis flag. It is then compared against a full reference. A mode strap picks that reference: either the learned full value or the programmed full count.

The segments are split into two banks that take turns on a shared time base, and each bank is driven for only part of every period. The display lights while a push-button window is open, or while charge or fast-discharge activity is reported and the button is idle. Segment 1 blinks when the battery is near empty. A test override drives the segments directly, and a disable strap turns everything off. All timing comes from counters on the system clock, and every interval is a parameter.

Top module: `led_gauge`

## Requirements
- R1: The full reference is `pfc_i` when `abs_mode_i` is 1 and `lmd_i` when it is 0.
- R2: Segment k (k = 1..5, driven on `seg_no[k-1]`) is lit when scaled charge × 5 ≥ k × reference. The lit set always forms a thermometer code starting from segment 1.
- R3: Segments 1, 3 and 5 form bank A and segments 2 and 4 form bank B. The two banks are never driven in the same cycle. In every MUX_PERIOD clocks, a lit segment is driven low for exactly MUX_PERIOD×3/10 clocks.
- R4: Cold derating uses `temp_band_i` with this encoding: 0 = below -20°C, 1 = -20..-4°C, 2 = -4..0°C, 3 = 0..+4°C, 4..7 = above +4°C. Band 0 halves the charge (floor). Otherwise, while the cold flag is set, scaled = floor(3×charge/4). Bands 0 to 2 set the cold flag, bands 4 to 7 clear it, and band 3 holds it. The flag is clear after reset.
- R5: A falling edge on `pb_ni` opens a display window of PB_TICKS clocks. The edge is seen through a two-stage synchronizer.
- R6: While `pb_ni` is high (idle), the display is on whenever `chg_act_i` or `fdis_act_i` is 1. While `pb_ni` is held low, activity does not light the display. With no window open and no qualifying activity, all segments stay off.
- R7: When `edv_i` is 1, or when scaled × 10 < reference, segment 1 shows a blink. The blink is on and off for BLINK_HALF clocks each, starting in the on state at reset, and is still gated by its bank.
- R8: `gauge_o` equals min(15, floor(scaled × 16 / reference)).
- R9: When `ovr_en_i` is 1, the next cycle drives `seg_no = ~ovr_seg_i`, with no multiplexing and no dependence on whether the display is enabled.
- R10: When `disable_i` is 1, the next cycle drives all of `seg_no` high, whatever the other inputs are.
- R11: During reset, `seg_no` is all ones and `gauge_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nac_i | input | CNT_W | Available-charge count |
| lmd_i | input | CNT_W | Learned full value |
| pfc_i | input | CNT_W | Programmed full count |
| abs_mode_i | input | 1 | 1 selects the programmed full count as the reference |
| temp_band_i | input | 3 | Temperature band code (see R4) |
| pb_ni | input | 1 | Push-button, active low, high when idle |
| chg_act_i | input | 1 | Charge activity above the display threshold |
| fdis_act_i | input | 1 | Fast-discharge activity |
| edv_i | input | 1 | Low-battery flag |
| ovr_en_i | input | 1 | Override enable |
| ovr_seg_i | input | 5 | Override segment pattern, 1 = lit |
| disable_i | input | 1 | Disable strap |
| seg_no | output | 5 | Segment drives, active low |
| gauge_o | output | 4 | Gauge field in sixteenths |

## Verification
The assertions assume the following about the inputs:
- The reference is nonzero.
- `temp_band_i` carries only the encoded band codes.
- The charge and reference inputs stay stable for the length of one multiplexing measurement window.

The stimulus changes every input only on the falling clock edge and then holds it. Segment activity is measured over whole multiples of both the multiplexing period and the blink period. Because of this, the on-counts do not depend on the phase at which a measurement starts.

// File: rtl/led_gauge_pkg.sv
package led_gauge_pkg;
  localparam int unsigned NUM_SEG = 5;
  localparam int unsigned GG_W    = 4;
  localparam int unsigned GG_MAX  = 15;

  typedef enum logic [1:0] {
    DER_NONE,
    DER_3Q,
    DER_HALF
  } derate_e;
endpackage

// File: rtl/led_gauge_scale.sv
module led_gauge_scale
  import led_gauge_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       temp_band_i,
  input  logic [CNT_W-1:0] nac_i,
  output logic [CNT_W-1:0] scaled_o
);
  localparam int unsigned EXT_W = CNT_W + 2;

  logic              cold_q;
  derate_e           derate;
  logic [EXT_W-1:0]  triple;

  // hysteresis: band 3 (0..+4C) keeps the previous decision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cold_q <= 1'b0;
    else if (temp_band_i <= 3'd2) cold_q <= 1'b1;
    else if (temp_band_i >= 3'd4) cold_q <= 1'b0;
  end

  always_comb begin
    if (temp_band_i == 3'd0) derate = DER_HALF;
    else if (cold_q)         derate = DER_3Q;
    else                     derate = DER_NONE;
  end

  assign triple = EXT_W'(nac_i) * EXT_W'(3);

  always_comb begin
    unique case (derate)
      DER_HALF: scaled_o = nac_i >> 1;
      DER_3Q:   scaled_o = CNT_W'(triple >> 2);
      default:  scaled_o = nac_i;
    endcase
  end

  p_cold_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_band_i == 3'd3) |=> $stable(cold_q));

  p_half_band_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_band_i == 3'd0) |-> (scaled_o <= (nac_i >> 1)));
endmodule

// File: rtl/led_gauge_level.sv
module led_gauge_level
  import led_gauge_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0]   scaled_i,
  input  logic [CNT_W-1:0]   ref_i,
  output logic [NUM_SEG-1:0] lit_o,
  output logic               low_o,
  output logic [GG_W-1:0]    gauge_o
);
  localparam int unsigned PROD_W = CNT_W + 5;

  logic [PROD_W-1:0] s_ext, r_ext, s5, s16;
  logic [GG_MAX-1:0] ge;

  assign s_ext = PROD_W'(scaled_i);
  assign r_ext = PROD_W'(ref_i);
  assign s5    = s_ext * PROD_W'(5);
  assign s16   = s_ext << 4;
  assign low_o = (s_ext * PROD_W'(10)) < r_ext;

  for (genvar k = 1; k <= NUM_SEG; k++) begin : g_seg
    assign lit_o[k-1] = s5 >= (PROD_W'(k) * r_ext);
  end

  for (genvar g = 1; g <= GG_MAX; g++) begin : g_step
    assign ge[g-1] = s16 >= (PROD_W'(g) * r_ext);
  end

  always_comb begin
    gauge_o = '0;
    for (int g = 1; g <= GG_MAX; g++) begin
      if (ge[g-1]) gauge_o = GG_W'(g);
    end
  end
endmodule

// File: rtl/led_gauge_timing.sv
module led_gauge_timing #(
  parameter int unsigned MUX_PERIOD = 390625,
  parameter int unsigned BLINK_HALF = 15625000,
  parameter int unsigned PB_TICKS   = 500000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pb_ni,
  output logic bank_a_o,
  output logic bank_b_o,
  output logic blink_o,
  output logic pb_win_o,
  output logic pb_idle_o
);
  localparam int unsigned SLOT = MUX_PERIOD / 2;
  localparam int unsigned ON   = (MUX_PERIOD * 3) / 10;
  localparam int unsigned PH_W = $clog2(MUX_PERIOD);
  localparam int unsigned BL_W = $clog2(BLINK_HALF);
  localparam int unsigned PB_W = $clog2(PB_TICKS + 1);

  logic [PH_W-1:0] phase_q;
  logic [BL_W-1:0] blink_cnt_q;
  logic            blink_q;
  logic [1:0]      pb_sync_q;
  logic            pb_prev_q;
  logic            pb_fall;
  logic [PB_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 phase_q <= '0;
    else if (phase_q == PH_W'(MUX_PERIOD - 1))   phase_q <= '0;
    else                                         phase_q <= phase_q + 1'b1;
  end

  assign bank_a_o = phase_q < PH_W'(ON);
  assign bank_b_o = (phase_q >= PH_W'(SLOT)) && (phase_q < PH_W'(SLOT + ON));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blink_cnt_q <= '0;
      blink_q     <= 1'b1;
    end else if (blink_cnt_q == BL_W'(BLINK_HALF - 1)) begin
      blink_cnt_q <= '0;
      blink_q     <= ~blink_q;
    end else begin
      blink_cnt_q <= blink_cnt_q + 1'b1;
    end
  end

  assign blink_o = blink_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pb_sync_q <= 2'b11;
      pb_prev_q <= 1'b1;
    end else begin
      pb_sync_q <= {pb_sync_q[0], pb_ni};
      pb_prev_q <= pb_sync_q[1];
    end
  end

  assign pb_fall   = pb_prev_q & ~pb_sync_q[1];
  assign pb_idle_o = pb_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          win_q <= '0;
    else if (pb_fall)     win_q <= PB_W'(PB_TICKS);
    else if (win_q != '0) win_q <= win_q - 1'b1;
  end

  assign pb_win_o = win_q != '0;

  p_pb_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_fall |=> pb_win_o);

  p_bank_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bank_a_o && bank_b_o));
endmodule

// File: rtl/led_gauge.sv
module led_gauge
  import led_gauge_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned MUX_PERIOD = 390625,
  parameter int unsigned BLINK_HALF = 15625000,
  parameter int unsigned PB_TICKS   = 500000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] nac_i,
  input  logic [CNT_W-1:0] lmd_i,
  input  logic [CNT_W-1:0] pfc_i,
  input  logic             abs_mode_i,
  input  logic [2:0]       temp_band_i,
  input  logic             pb_ni,
  input  logic             chg_act_i,
  input  logic             fdis_act_i,
  input  logic             edv_i,
  input  logic             ovr_en_i,
  input  logic [4:0]       ovr_seg_i,
  input  logic             disable_i,
  output logic [4:0]       seg_no,
  output logic [3:0]       gauge_o
);
  logic [CNT_W-1:0]   full_ref;
  logic [CNT_W-1:0]   scaled;
  logic [NUM_SEG-1:0] lit, lit_eff, gate, seg_d, seg_q;
  logic               low;
  logic [GG_W-1:0]    gauge_d, gauge_q;
  logic               bank_a, bank_b, blink, pb_win, pb_idle;
  logic               disp_en;

  assign full_ref = abs_mode_i ? pfc_i : lmd_i;

  led_gauge_scale #(.CNT_W(CNT_W)) u_scale (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .temp_band_i (temp_band_i),
    .nac_i       (nac_i),
    .scaled_o    (scaled)
  );

  led_gauge_level #(.CNT_W(CNT_W)) u_level (
    .scaled_i (scaled),
    .ref_i    (full_ref),
    .lit_o    (lit),
    .low_o    (low),
    .gauge_o  (gauge_d)
  );

  led_gauge_timing #(
    .MUX_PERIOD (MUX_PERIOD),
    .BLINK_HALF (BLINK_HALF),
    .PB_TICKS   (PB_TICKS)
  ) u_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pb_ni     (pb_ni),
    .bank_a_o  (bank_a),
    .bank_b_o  (bank_b),
    .blink_o   (blink),
    .pb_win_o  (pb_win),
    .pb_idle_o (pb_idle)
  );

  assign disp_en = pb_win | (pb_idle & (chg_act_i | fdis_act_i));

  // segment 1 is forced to the blink pattern when near empty
  assign lit_eff = {lit[NUM_SEG-1:1], (edv_i | low) ? blink : lit[0]};

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_gate
    if (k % 2 == 0) begin : g_a
      assign gate[k] = bank_a;
    end else begin : g_b
      assign gate[k] = bank_b;
    end
  end

  always_comb begin
    if (disable_i)     seg_d = '1;
    else if (ovr_en_i) seg_d = ~ovr_seg_i;
    else if (disp_en)  seg_d = ~(lit_eff & gate);
    else               seg_d = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q   <= '1;
      gauge_q <= '0;
    end else begin
      seg_q   <= seg_d;
      gauge_q <= gauge_d;
    end
  end

  assign seg_no  = seg_q;
  assign gauge_o = gauge_q;

  p_bank_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ovr_en_i) |-> !((!seg_no[0] || !seg_no[2] || !seg_no[4]) &&
                           (!seg_no[1] || !seg_no[3])));

  p_disable_dark_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(disable_i) |-> (seg_no == 5'h1f));

  p_override_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovr_en_i && !disable_i) |-> (seg_no == ~$past(ovr_seg_i)));

  p_thermo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lit & (lit + 1'b1)) == '0);

  p_full_gauge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lit[NUM_SEG-1] |=> (gauge_o == 4'd15));
endmodule

// File: tb/led_gauge_tb.sv
module led_gauge_tb;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned MUXP   = 20;
  localparam int unsigned BLINKH = 40;
  localparam int unsigned PBT    = 400;
  localparam int unsigned ON     = MUXP * 3 / 10;
  localparam int unsigned WIN    = 2 * BLINKH;
  localparam int unsigned FULL   = ON * (WIN / MUXP);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] nac = '0, lmd = 8'd200, pfc = 8'd160;
  logic             abs_mode = 1'b0;
  logic [2:0]       band = 3'd7;
  logic             pb_n = 1'b1, chg = 1'b0, fdis = 1'b0, edv = 1'b0;
  logic             ovr_en = 1'b0, dis = 1'b0;
  logic [4:0]       ovr_seg = '0;
  logic [4:0]       seg_no;
  logic [3:0]       gauge;

  int errors = 0;
  int checks = 0;
  int on_cnt [5];

  always #4 clk = ~clk;

  led_gauge #(
    .CNT_W(CNT_W), .MUX_PERIOD(MUXP), .BLINK_HALF(BLINKH), .PB_TICKS(PBT)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .nac_i(nac), .lmd_i(lmd), .pfc_i(pfc),
    .abs_mode_i(abs_mode), .temp_band_i(band), .pb_ni(pb_n), .chg_act_i(chg),
    .fdis_act_i(fdis), .edv_i(edv), .ovr_en_i(ovr_en), .ovr_seg_i(ovr_seg),
    .disable_i(dis), .seg_no(seg_no), .gauge_o(gauge)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_on();
    for (int k = 0; k < 5; k++) on_cnt[k] = 0;
    repeat (WIN) begin
      @(negedge clk);
      for (int k = 0; k < 5; k++) if (!seg_no[k]) on_cnt[k]++;
    end
  endtask

  function automatic int scale_of(input int n, input int b, input bit cold);
    if (b == 0) return n / 2;
    if (cold)   return (n * 3) / 4;
    return n;
  endfunction

  function automatic int gauge_of(input int s, input int r);
    int e = (s * 16) / r;
    return (e > 15) ? 15 : e;
  endfunction

  task automatic check_segs(input int s, input int r, input bit blink_on, input string tag);
    for (int k = 1; k <= 5; k++) begin
      int exp;
      if (k == 1 && (blink_on || s * 10 < r)) exp = FULL / 2;
      else if (s * 5 >= k * r)                exp = FULL;
      else                                    exp = 0;
      chk(on_cnt[k-1] == exp, tag, on_cnt[k-1], exp);
    end
  endtask

  // R1 R2 R3 R7 R8 sweep of the charge count
  task automatic sweep(input bit mode, input int b, input bit cold, input int step);
    int r = mode ? int'(pfc) : int'(lmd);
    abs_mode = mode;
    band = 3'(b);
    for (int n = 0; n < 256; n += step) begin
      int s;
      nac = 8'(n);
      wait_n(3);
      s = scale_of(n, b, cold);
      chk(int'(gauge) == gauge_of(s, r), "R8/R1 gauge", int'(gauge), gauge_of(s, r));
      count_on();
      check_segs(s, r, 1'b0, "R2/R3/R1 segment on-count");
    end
  endtask

  task automatic hyst_step(input int b, input int exp_g);
    band = 3'(b);
    wait_n(4);
    chk(int'(gauge) == exp_g, "R4 hysteresis gauge", int'(gauge), exp_g);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(3);
    chk(seg_no == 5'h1f, "R11 reset segments", int'(seg_no), 31);
    chk(gauge == 4'd0, "R11 reset gauge", int'(gauge), 0);
    rst_n = 1'b1;

    // R6: no window, no activity -> dark
    nac = 8'd200;
    wait_n(3);
    count_on();
    for (int k = 0; k < 5; k++) chk(on_cnt[k] == 0, "R6 idle dark", on_cnt[k], 0);

    chg = 1'b1;
    sweep(1'b0, 7, 1'b0, 1);
    sweep(1'b1, 7, 1'b0, 1);
    sweep(1'b0, 0, 1'b1, 5);   // R4 band 0 halving

    // R4 hysteresis, reference 200, charge 200
    abs_mode = 1'b0;
    nac = 8'd200;
    hyst_step(5, 15);
    hyst_step(3, 15);
    hyst_step(2, 12);
    hyst_step(3, 12);
    hyst_step(4, 15);
    hyst_step(1, 12);
    hyst_step(7, 15);

    // R7: low-battery flag blinks segment 1 at full charge
    edv = 1'b1;
    wait_n(3);
    count_on();
    check_segs(200, 200, 1'b1, "R7 blink with flag");
    edv = 1'b0;

    // R6: fast discharge alone with idle button
    chg = 1'b0;
    fdis = 1'b1;
    wait_n(3);
    count_on();
    check_segs(200, 200, 1'b0, "R6 fast discharge display");
    fdis = 1'b0;
    wait_n(3);
    count_on();
    for (int k = 0; k < 5; k++) chk(on_cnt[k] == 0, "R6 activity off dark", on_cnt[k], 0);

    // R5: push-button window
    pb_n = 1'b0;
    wait_n(5);
    pb_n = 1'b1;
    wait_n(25);
    count_on();
    check_segs(200, 200, 1'b0, "R5 window open");
    wait_n(PBT - 110 + 40);
    count_on();
    for (int k = 0; k < 5; k++) chk(on_cnt[k] == 0, "R5 window closed", on_cnt[k], 0);

    // R6: held button blocks activity once the window has expired
    pb_n = 1'b0;
    chg = 1'b1;
    wait_n(PBT + 20);
    count_on();
    for (int k = 0; k < 5; k++) chk(on_cnt[k] == 0, "R6 held button", on_cnt[k], 0);
    pb_n = 1'b1;
    wait_n(5);
    count_on();
    check_segs(200, 200, 1'b0, "R6 release with activity");

    // R9 override
    ovr_seg = 5'b10101;
    ovr_en = 1'b1;
    wait_n(2);
    for (int i = 0; i < 7; i++) begin
      chk(seg_no == 5'b01010, "R9 override pattern", int'(seg_no), 10);
      wait_n(3);
    end
    ovr_seg = 5'b00011;
    wait_n(2);
    chk(seg_no == 5'b11100, "R9 override pattern 2", int'(seg_no), 28);

    // R10 disable beats override and activity
    dis = 1'b1;
    wait_n(2);
    count_on();
    for (int k = 0; k < 5; k++) chk(on_cnt[k] == 0, "R10 disable dark", on_cnt[k], 0);
    ovr_en = 1'b0;
    wait_n(2);
    count_on();
    for (int k = 0; k < 5; k++) chk(on_cnt[k] == 0, "R10 disable with activity", on_cnt[k], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule